// File: doc/BRIEF.md
# Serial NAND Feature Register Target

This block is the device-side control plane of a serial NAND flash target. It listens on a single-lane, mode-0 serial port (clock idle low, bits sampled on the rising edge and launched on the falling edge, most significant bit first). It keeps three 8-bit feature registers: a block-protection byte, a configuration byte and a status byte. The port's clock, select and data lines are synchronised into the fabric clock `clk`, so the serial clock must run well below `clk`.

A register read frame carries an opcode byte, a register address byte, and then eight clocks in which the block drives the addressed byte. A register write frame carries an opcode byte, an address byte and one data byte. Three single-byte commands set the write-enable latch, clear it, and restore the power-on register contents. The array engine drives the array-side status bits (busy, erase failure, program failure, ECC result) as side inputs. The protection and configuration bytes and the latch are also driven out, so the array engine can act on them.

Top module: `nand_feat_target`

## Requirements
- R1: After synchronous reset, `prot_bits` is 0x38, `cfg_bits` is 0x10, `wr_latch` is 0 and `spi_miso` is 0.
- R2: A read frame (opcode 0x0F, then an address byte) returns the addressed byte MSB first on `spi_miso`. Each bit is valid at the 17th to 24th rising serial clock edge of the frame.
- R3: A write frame (opcode 0x1F, address 0xA0, data byte) replaces the writable bits of the protection byte at the 24th rising edge. Only bits 6:1 (mask 0x7E) are writable and the rest read 0. The value 0x00 means no block is protected.
- R4: A write frame to address 0xB0 updates configuration bits 6 (one-time-programmable area select), 4 (on-die ECC enable) and 0 (four-lane data enable). All other configuration bits read 0.
- R5: Address 0xC0 reads as status with this layout: bit 0 busy, bit 1 write-enable latch, bit 2 erase failed, bit 3 program failed, bits 5:4 ECC result (0 clean, 1 corrected, 2 uncorrectable), bits 7:6 zero. The side inputs are sampled when the address byte completes.
- R6: A write frame to the status address or to any unlisted address changes neither the protection byte nor the configuration byte.
- R7: A read frame to an unlisted address returns 0x00.
- R8: Opcode 0x06 sets `wr_latch` and opcode 0x04 clears it, when the opcode byte completes.
- R9: Opcode 0xFF restores the protection byte to 0x38 and the configuration byte to 0x10, and clears `wr_latch`.
- R10: Each select assertion starts a new frame. A write frame ended by select rising before its 24th bit has no effect. An unknown opcode has no effect and leaves `spi_miso` at 0.
- R11: `spi_miso` is 0 while the target is deselected and outside the data phase of a read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low target select |
| spi_mosi | input | 1 | Serial data into the target |
| spi_miso | output | 1 | Serial data out of the target |
| arr_busy | input | 1 | Array operation in progress |
| arr_erase_fail | input | 1 | Last erase failed |
| arr_prog_fail | input | 1 | Last program failed |
| arr_ecc_state | input | 2 | ECC result of the last page read |
| prot_bits | output | 8 | Current block-protection byte |
| cfg_bits | output | 8 | Current configuration byte |
| wr_latch | output | 1 | Write-enable latch |

## Verification
A bit counter that slips by one position shows at the ports in two ways. A read frame returns the byte shifted by one place on `spi_miso`. A write frame either never commits or commits the wrong value, and `prot_bits` or `cfg_bits` shows this a few fabric clocks after the 24th serial edge. A wrong write mask or a wrong address decode is visible on the register outputs in the idle gap after that same frame. A latch that is stuck or slow shows on `wr_latch` directly, and also in bit 1 of the next status read. Because the bench compares the register outputs against its model on every idle clock, any such fault is reported within one frame of the command that exposes it.

// File: rtl/nfr_pkg.sv
package nfr_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t OP_RD_FEAT = 8'h0F;
  localparam byte_t OP_WR_FEAT = 8'h1F;
  localparam byte_t OP_WREN    = 8'h06;
  localparam byte_t OP_WRDI    = 8'h04;
  localparam byte_t OP_RESET   = 8'hFF;

  localparam byte_t ADR_PROT = 8'hA0;
  localparam byte_t ADR_CFG  = 8'hB0;
  localparam byte_t ADR_STAT = 8'hC0;
endpackage

// File: rtl/nfr_spi_rx.sv
module nfr_spi_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sel,
  output logic rise,
  output logic fall,
  output logic bit_in
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sck_sr, cs_sr, mosi_sr;
  logic         sck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sr   <= '0;
      cs_sr    <= '1;
      mosi_sr  <= '0;
      sck_last <= 1'b0;
    end else begin
      sck_sr   <= {sck_sr[TOP-1:0], sck};
      cs_sr    <= {cs_sr[TOP-1:0], cs_n};
      mosi_sr  <= {mosi_sr[TOP-1:0], mosi};
      sck_last <= sck_sr[TOP];
    end
  end

  assign sel    = ~cs_sr[TOP];
  assign rise   = sel & sck_sr[TOP] & ~sck_last;
  assign fall   = sel & ~sck_sr[TOP] & sck_last;
  assign bit_in = mosi_sr[TOP];
endmodule

// File: rtl/nfr_frame.sv
module nfr_frame
  import nfr_pkg::*;
#(
  parameter int FRAME_BYTES = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  sel,
  input  logic  rise,
  input  logic  bit_in,
  output logic  op_done,
  output logic  addr_done,
  output logic  data_done,
  output byte_t opcode,
  output byte_t addr,
  output byte_t data
);
  localparam int FRAME_BITS = BYTE_W * FRAME_BYTES;
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] END_OP   = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] END_ADDR = CW'(2 * BYTE_W - 1);
  localparam logic [CW-1:0] END_DATA = CW'(3 * BYTE_W - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(FRAME_BITS);

  logic [CW-1:0] cnt;
  byte_t         sh, nxt;

  assign nxt = {sh[BYTE_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    op_done   <= 1'b0;
    addr_done <= 1'b0;
    data_done <= 1'b0;
    if (rst || !sel) begin
      cnt    <= '0;
      sh     <= '0;
      opcode <= '0;
      addr   <= '0;
      data   <= '0;
    end else if (rise && cnt < CNT_MAX) begin
      sh  <= nxt;
      cnt <= cnt + 1'b1;
      if (cnt == END_OP) begin
        opcode  <= nxt;
        op_done <= 1'b1;
      end
      if (cnt == END_ADDR) begin
        addr      <= nxt;
        addr_done <= 1'b1;
      end
      if (cnt == END_DATA) begin
        data      <= nxt;
        data_done <= 1'b1;
      end
    end
  end

  // R10: a deselect always rewinds the frame position
  assert_rewind_R10: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (cnt == '0 && !data_done));
endmodule

// File: rtl/nfr_regs.sv
module nfr_regs
  import nfr_pkg::*;
#(
  parameter byte_t PROT_DEF  = 8'h38,
  parameter byte_t PROT_MASK = 8'h7E,
  parameter byte_t CFG_DEF   = 8'h10,
  parameter byte_t CFG_MASK  = 8'h51
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       op_done,
  input  logic       data_done,
  input  byte_t      opcode,
  input  byte_t      addr,
  input  byte_t      data,
  input  logic       busy,
  input  logic       erase_fail,
  input  logic       prog_fail,
  input  logic [1:0] ecc_state,
  output byte_t      prot_q,
  output byte_t      cfg_q,
  output logic       wel_q,
  output byte_t      rd_data
);
  logic  do_write, do_reset;
  byte_t stat;

  assign do_write = data_done && (opcode == OP_WR_FEAT);
  assign do_reset = op_done && (opcode == OP_RESET);
  assign stat     = {2'b00, ecc_state, prog_fail, erase_fail, wel_q, busy};

  always_ff @(posedge clk) begin
    if (rst || do_reset) begin
      prot_q <= PROT_DEF;
      cfg_q  <= CFG_DEF;
      wel_q  <= 1'b0;
    end else begin
      if (do_write && addr == ADR_PROT) prot_q <= data & PROT_MASK;
      if (do_write && addr == ADR_CFG)  cfg_q  <= data & CFG_MASK;
      if (op_done && opcode == OP_WREN) wel_q <= 1'b1;
      if (op_done && opcode == OP_WRDI) wel_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      ADR_PROT: rd_data = prot_q;
      ADR_CFG:  rd_data = cfg_q;
      ADR_STAT: rd_data = stat;
      default:  rd_data = '0;
    endcase
  end

  assert_wren_R8: assert property (@(posedge clk) disable iff (rst)
    (op_done && opcode == OP_WREN) |=> wel_q);
  assert_wrdi_R8: assert property (@(posedge clk) disable iff (rst)
    (op_done && opcode == OP_WRDI) |=> !wel_q);
  assert_defaults_R9: assert property (@(posedge clk) disable iff (rst)
    do_reset |=> (prot_q == PROT_DEF && cfg_q == CFG_DEF && !wel_q));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!do_reset && !(do_write && (addr == ADR_PROT || addr == ADR_CFG)))
      |=> ($stable(prot_q) && $stable(cfg_q)));
endmodule

// File: rtl/nand_feat_target.sv
module nand_feat_target
  import nfr_pkg::*;
#(
  parameter int    SYNC_STAGES = 2,
  parameter byte_t PROT_DEF    = 8'h38,
  parameter byte_t PROT_MASK   = 8'h7E,
  parameter byte_t CFG_DEF     = 8'h10,
  parameter byte_t CFG_MASK    = 8'h51
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic       arr_busy,
  input  logic       arr_erase_fail,
  input  logic       arr_prog_fail,
  input  logic [1:0] arr_ecc_state,
  output logic [7:0] prot_bits,
  output logic [7:0] cfg_bits,
  output logic       wr_latch
);
  logic  sel, rise, fall, bit_in;
  logic  op_done, addr_done, data_done;
  byte_t opcode, addr, data, rd_data, tx;

  nfr_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) rx_i (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sel(sel), .rise(rise), .fall(fall), .bit_in(bit_in)
  );

  nfr_frame #(.FRAME_BYTES(3)) frame_i (
    .clk(clk), .rst(rst), .sel(sel), .rise(rise), .bit_in(bit_in),
    .op_done(op_done), .addr_done(addr_done), .data_done(data_done),
    .opcode(opcode), .addr(addr), .data(data)
  );

  nfr_regs #(
    .PROT_DEF(PROT_DEF), .PROT_MASK(PROT_MASK),
    .CFG_DEF(CFG_DEF), .CFG_MASK(CFG_MASK)
  ) regs_i (
    .clk(clk), .rst(rst), .op_done(op_done), .data_done(data_done),
    .opcode(opcode), .addr(addr), .data(data),
    .busy(arr_busy), .erase_fail(arr_erase_fail), .prog_fail(arr_prog_fail),
    .ecc_state(arr_ecc_state),
    .prot_q(prot_bits), .cfg_q(cfg_bits), .wel_q(wr_latch), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      tx       <= '0;
      spi_miso <= 1'b0;
    end else if (addr_done && opcode == OP_RD_FEAT) begin
      tx <= rd_data;
    end else if (fall) begin
      spi_miso <= tx[BYTE_W-1];
      tx       <= {tx[BYTE_W-2:0], 1'b0};
    end
  end

  // R11: output line returns low as soon as the target is deselected
  assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !spi_miso);
endmodule

// File: tb/nand_feat_target_tb_top.sv
module nand_feat_target_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic busy = 1'b0, efail = 1'b0, pfail = 1'b0;
  logic [1:0] ecc = 2'd0;
  logic [7:0] prot, cfg;
  logic wel;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;
  bit done   = 1'b0;

  logic [7:0] m_prot = 8'h38;
  logic [7:0] m_cfg  = 8'h10;
  logic       m_wel  = 1'b0;

  always #10 clk = ~clk;

  nand_feat_target dut_i (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .arr_busy(busy), .arr_erase_fail(efail),
    .arr_prog_fail(pfail), .arr_ecc_state(ecc),
    .prot_bits(prot), .cfg_bits(cfg), .wr_latch(wel)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      check("R3 prot", prot, m_prot);
      check("R4 cfg", cfg, m_cfg);
      check("R8 latch", {7'd0, wel}, {7'd0, m_wel});
      check("R11 idle miso", {7'd0, miso}, 8'd0);
    end
  end

  // Drives nbits of word (MSB first). For a read frame, checks the data phase
  // against exp_rd; otherwise expects miso low on every bit.
  task automatic xfer(input logic [23:0] word, input int nbits,
                      input bit is_rd, input logic [7:0] exp_rd, input string req);
    cmp_en = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = word[23-i];
      wait_clk(HALF);
      if (is_rd && i >= 16) check(req, {7'd0, miso}, {7'd0, exp_rd[23-i]});
      else                  check("R11 miso low", {7'd0, miso}, 8'd0);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(2 * HALF);
    cmp_en = 1'b1;
  endtask

  task automatic rd_feat(input logic [7:0] a, input logic [7:0] exp, input string req);
    xfer({8'h0F, a, 8'h00}, 24, 1'b1, exp, req);
  endtask

  task automatic wr_feat(input logic [7:0] a, input logic [7:0] v, input int nbits);
    if (nbits == 24) begin
      if (a == 8'hA0) m_prot = v & 8'h7E;
      if (a == 8'hB0) m_cfg  = v & 8'h51;
    end
    xfer({8'h1F, a, v}, nbits, 1'b0, 8'h00, "R10");
  endtask

  task automatic cmd(input logic [7:0] op);
    if (op == 8'h06) m_wel = 1'b1;
    if (op == 8'h04) m_wel = 1'b0;
    if (op == 8'hFF) begin m_prot = 8'h38; m_cfg = 8'h10; m_wel = 1'b0; end
    xfer({op, 16'h0000}, 8, 1'b0, 8'h00, "R10");
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R1 reset state
    check("R1 prot", prot, 8'h38);
    check("R1 cfg", cfg, 8'h10);
    check("R1 latch", {7'd0, wel}, 8'd0);
    check("R1 miso", {7'd0, miso}, 8'd0);
    cmp_en = 1'b1;

    // R2 read frames
    rd_feat(8'hA0, 8'h38, "R2 read prot");
    rd_feat(8'hB0, 8'h10, "R2 read cfg");

    // R4 config mask
    wr_feat(8'hB0, 8'hFF, 24);
    rd_feat(8'hB0, 8'h51, "R4 cfg masked");
    wr_feat(8'hB0, 8'h01, 24);
    rd_feat(8'hB0, 8'h01, "R4 quad only");

    // R3 protection byte
    wr_feat(8'hA0, 8'h00, 24);
    rd_feat(8'hA0, 8'h00, "R3 unlocked");
    wr_feat(8'hA0, 8'hFF, 24);
    rd_feat(8'hA0, 8'h7E, "R3 prot masked");

    // R8 + R5 status
    cmd(8'h06);
    busy = 1'b1; ecc = 2'd2; pfail = 1'b1; efail = 1'b0;
    rd_feat(8'hC0, 8'h2B, "R5 status busy/uncorr/wel");
    cmd(8'h04);
    busy = 1'b0; ecc = 2'd1; pfail = 1'b0; efail = 1'b1;
    rd_feat(8'hC0, 8'h14, "R5 status corrected/erase");

    // R6 ignored writes
    wr_feat(8'hC0, 8'hFF, 24);
    rd_feat(8'hC0, 8'h14, "R6 status unchanged");
    wr_feat(8'h90, 8'hFF, 24);
    check("R6 prot kept", prot, 8'h7E);
    check("R6 cfg kept", cfg, 8'h01);

    // R7 unknown read
    rd_feat(8'h55, 8'h00, "R7 unknown addr");

    // R10 aborted write and unknown opcode
    wr_feat(8'hB0, 8'h40, 20);
    check("R10 abort cfg", cfg, 8'h01);
    xfer({8'hAB, 8'hB0, 8'h40}, 24, 1'b0, 8'h00, "R10 unknown op");
    check("R10 unknown op cfg", cfg, 8'h01);

    // R9 device reset
    cmd(8'h06);
    cmd(8'hFF);
    check("R9 prot", prot, 8'h38);
    check("R9 cfg", cfg, 8'h10);
    check("R9 latch", {7'd0, wel}, 8'd0);
    rd_feat(8'hB0, 8'h10, "R9 read cfg");

    done = 1'b1;
    cmp_en = 1'b0;
    summary();
    $finish;
  end
endmodule